// File: doc/BRIEF.md
# SPI Command-Word Transfer Engine

This block is the master-side frame sequencer of an SPI controller. It consumes 32-bit queue entries, one at a time. The upper half of each entry is a command and the lower half is the data word. For each entry the engine runs exactly one SPI frame. It asserts one of its chip-select outputs, generates SCK, shifts the data out on `mosi` and samples `miso` into a receive word. When the frame ends, it hands the receive word onward with a one-cycle valid pulse.

The command chooses four things:
- which chip select to drive;
- which of the attribute sets to use (frame length, bit order, clock polarity, clock phase);
- whether chip select stays asserted for a following frame to the same target;
- whether the frame closes the queue.

A clear bit in the command zeroes the frame counter before the frame is sent. A halt input blocks the start of new frames. Halt is looked at only between frames, so a frame that has started always finishes.

Delays are fixed by parameters, all counted in clock cycles:
- SCK half-period;
- chip-select-to-first-edge time;
- last-edge-to-release time;
- minimum deselect gap between frames.

Command layout, with bit positions in the 32-bit entry:

| Bits | Meaning |
|---|---|
| 31 | keep chip select |
| 30:28 | attribute set index |
| 27 | end of queue |
| 26 | clear counter |
| 18:16 | chip-select index |
| 15:0 | data |

Top module: `spi_cmd_engine`

## Requirements
- R1: The frame length comes from the 4-bit length field of the selected attribute set. A field value v gives max(v,3)+1 bits, so the range is 4 to 16. Exactly that many capture edges are produced on SCK.
- R2: A bit-order flag of 0 in the selected set sends the most significant of the frame bits first. A flag of 1 sends bit 0 first.
- R3: SCK rests at the set's polarity level outside a frame and returns to it after the last edge. With phase 0, data is captured on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and captured on the trailing edge.
- R4: Command bits 18:16 select the chip-select output. At most one output is active at a time. Each output is active high when its `cs_active_high` bit is 1 and active low when that bit is 0.
- R5: Suppose a frame has the keep bit (31) set and the next entry names the same chip select. Then chip select stays active with no inactive cycle between the two frames.
- R6: Suppose the keep bit is clear, or the next entry names a different chip select. Then all chip selects go inactive for the deselect gap. When the next entry is already waiting, this is exactly AFTER_XFER+1 cycles.
- R7: The clear bit (26) zeroes the frame counter when that entry is taken, so the counter reads 1 once that frame completes.
- R8: The frame counter increments by one per completed frame and wraps from all ones to zero.
- R9: Each completed frame gives a one-cycle `xfer_done` pulse, together with `rx_valid` and `rx_data`.
- R10: A frame with the end-of-queue bit (27) set raises `eoq_flag` when it completes. No new entry is taken until `eoq_clr` is pulsed.
- R11: While `halt` is high, no new entry is taken. A frame already started still completes.
- R12: Received bits are right-aligned in `rx_data` and follow the same bit order as the transmitted bits. Bits above the frame length are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_valid | input | 1 | A queue entry is offered |
| entry_data | input | 32 | Command (31:16) and data (15:0) |
| entry_ready | output | 1 | Entry taken on this clock edge |
| halt | input | 1 | Block the start of new frames |
| eoq_clr | input | 1 | Clear the end-of-queue flag |
| attr_len_m1 | input | 4*NUM_ATTR | Per-set frame length minus one |
| attr_lsb_first | input | NUM_ATTR | Per-set bit order |
| attr_cpol | input | NUM_ATTR | Per-set SCK idle level |
| attr_cpha | input | NUM_ATTR | Per-set clock phase |
| cs_active_high | input | NUM_CS | Per-output chip-select polarity |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_out | output | NUM_CS | Chip-select outputs |
| rx_valid | output | 1 | Received word valid pulse |
| rx_data | output | 16 | Received word |
| xfer_done | output | 1 | Frame complete pulse |
| tcnt | output | CNT_W | Frame counter |
| eoq_flag | output | 1 | End of queue reached |

## Verification
The main sweep crosses all four clock modes with both bit orders, every frame length from 4 to 16, two data patterns and a rotating chip select. The bench drives `miso` as the inverse of `mosi`. A wrong capture edge, a shifted bit, a reversed order or a wrong mask therefore each shows up as a different mismatch: either in the recorded serial bit sequence or in the inverted received word.

Separate sequences cover the remaining behaviour:
- chip-select continuation, where a same-target follow-up must produce no gap but a cleared keep bit or a new target must produce the exact deselect gap;
- length field values below three;
- counter clear and wrap, using a narrow counter;
- end-of-queue blocking;
- halt raised both before and during a frame.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   localparam int KEEP_BIT = 31;
   localparam int ATTR_LSB = 28;
   localparam int EOQ_BIT  = 27;
   localparam int CLR_BIT  = 26;
   localparam int CS_LSB   = 16;
   localparam int WORD_W   = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_TRAIL,
      ST_HOLD,
      ST_GAP
   } eng_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spi_cmd_timer.sv
module spi_cmd_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
   parameter int DW = 16,
   parameter int LW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_word,
   input  logic [LW-1:0] load_len,
   input  logic          load_lsb,
   input  logic          shift_en,
   input  logic          cap_en,
   input  logic          miso,
   output logic          mosi,
   output logic [DW-1:0] rx_word
);

   logic [DW-1:0] tx_sr, rx_sr;
   logic [LW-1:0] len_q;
   logic          lsb_q;

   function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
      logic [DW-1:0] r;
      for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '0;
         rx_sr <= '0;
         len_q <= LW'(DW);
         lsb_q <= 1'b0;
      end else if (load) begin
         tx_sr <= load_lsb ? flip(load_word) : (load_word << (DW - int'(load_len)));
         rx_sr <= '0;
         len_q <= load_len;
         lsb_q <= load_lsb;
      end else begin
         if (shift_en) tx_sr <= tx_sr << 1;
         if (cap_en)   rx_sr <= {rx_sr[DW-2:0], miso};
      end
   end

   assign mosi = tx_sr[DW-1];

   always_comb begin
      rx_word = '0;
      for (int i = 0; i < DW; i++) begin
         if (i < int'(len_q)) begin
            if (lsb_q) rx_word[i] = rx_sr[int'(len_q) - 1 - i];
            else       rx_word[i] = rx_sr[i];
         end
      end
   end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int NUM_CS    = 6,
   parameter int NUM_ATTR  = 2,
   parameter int CNT_W     = 16,
   parameter int SCK_HALF  = 2,
   parameter int LEAD_CYC  = 2,
   parameter int TRAIL_CYC = 2,
   parameter int AFTER_XFER = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  entry_valid,
   input  logic [31:0]           entry_data,
   output logic                  entry_ready,
   input  logic                  halt,
   input  logic                  eoq_clr,
   input  logic [4*NUM_ATTR-1:0] attr_len_m1,
   input  logic [NUM_ATTR-1:0]   attr_lsb_first,
   input  logic [NUM_ATTR-1:0]   attr_cpol,
   input  logic [NUM_ATTR-1:0]   attr_cpha,
   input  logic [NUM_CS-1:0]     cs_active_high,
   input  logic                  miso,
   output logic                  sck,
   output logic                  mosi,
   output logic [NUM_CS-1:0]     cs_out,
   output logic                  rx_valid,
   output logic [WORD_W-1:0]     rx_data,
   output logic                  xfer_done,
   output logic [CNT_W-1:0]      tcnt,
   output logic                  eoq_flag
);

   localparam int LW   = $clog2(WORD_W + 1);
   localparam int ECW  = LW + 1;
   localparam int MAXC = imax(imax(SCK_HALF, LEAD_CYC), imax(TRAIL_CYC, AFTER_XFER));
   localparam int CW   = $clog2(MAXC + 1);

   if (NUM_CS < 1 || NUM_CS > 8)       $error("NUM_CS must be 1..8");
   if (NUM_ATTR < 1 || NUM_ATTR > 8)   $error("NUM_ATTR must be 1..8");
   if (CNT_W < 2)                      $error("CNT_W must be at least 2");
   if (SCK_HALF < 1 || LEAD_CYC < 1 || TRAIL_CYC < 1 || AFTER_XFER < 1)
      $error("all cycle counts must be at least 1");

   eng_state_e st_q, st_d;
   logic [2:0]     cs_idx_q;
   logic           keep_q, eoq_q, cpol_q, cpha_q, sck_r;
   logic [LW-1:0]  len_q;
   logic [ECW-1:0] ecnt;

   // attribute set chosen by the offered entry
   logic [2:0]    new_sel, new_idx;
   logic [3:0]    new_m1;
   logic          new_lsb, new_cpol, new_cpha;
   logic [LW-1:0] new_len;

   assign new_sel = entry_data[ATTR_LSB +: 3];
   assign new_idx = entry_data[CS_LSB +: 3];

   always_comb begin
      new_m1   = attr_len_m1[3:0];
      new_lsb  = attr_lsb_first[0];
      new_cpol = attr_cpol[0];
      new_cpha = attr_cpha[0];
      for (int a = 0; a < NUM_ATTR; a++) begin
         if (new_sel == 3'(a)) begin
            new_m1   = attr_len_m1[4*a +: 4];
            new_lsb  = attr_lsb_first[a];
            new_cpol = attr_cpol[a];
            new_cpha = attr_cpha[a];
         end
      end
      new_len = (new_m1 < 4'd3) ? LW'(4) : LW'(new_m1) + LW'(1);
   end

   // sequencing
   logic go, same_cs, pop, tmr_zero, tmr_ld, edge_ev, last_edge, lead_ev;
   logic [CW-1:0] tmr_val;

   assign go        = entry_valid && !halt && !eoq_flag;
   assign same_cs   = (new_idx == cs_idx_q);
   assign pop       = go && ((st_q == ST_IDLE) || ((st_q == ST_HOLD) && same_cs));
   assign edge_ev   = (st_q == ST_SHIFT) && tmr_zero;
   assign lead_ev   = ~ecnt[0];
   assign last_edge = edge_ev && (ecnt == ({len_q, 1'b0} - ECW'(1)));
   assign entry_ready = pop;

   always_comb begin
      st_d    = st_q;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      unique case (st_q)
         ST_IDLE: if (pop) begin
            st_d = ST_LEAD; tmr_ld = 1'b1; tmr_val = CW'(LEAD_CYC - 1);
         end
         ST_LEAD: if (tmr_zero) begin
            st_d = ST_SHIFT; tmr_ld = 1'b1; tmr_val = CW'(SCK_HALF - 1);
         end
         ST_SHIFT: if (edge_ev) begin
            tmr_ld = 1'b1;
            if (last_edge) begin
               st_d = ST_TRAIL; tmr_val = CW'(TRAIL_CYC - 1);
            end else begin
               tmr_val = CW'(SCK_HALF - 1);
            end
         end
         ST_TRAIL: if (tmr_zero) begin
            if (eoq_q || !keep_q) begin
               st_d = ST_GAP; tmr_ld = 1'b1; tmr_val = CW'(AFTER_XFER - 1);
            end else begin
               st_d = ST_HOLD;
            end
         end
         ST_HOLD: if (pop) begin
            st_d = ST_SHIFT; tmr_ld = 1'b1; tmr_val = CW'(SCK_HALF - 1);
         end else if (go && !same_cs) begin
            st_d = ST_GAP; tmr_ld = 1'b1; tmr_val = CW'(AFTER_XFER - 1);
         end
         ST_GAP: if (tmr_zero) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   spi_cmd_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_zero)
   );

   logic shift_en, cap_en;
   logic [WORD_W-1:0] rx_word;

   assign shift_en = edge_ev && (cpha_q ? (lead_ev && ecnt != '0) : !lead_ev);
   assign cap_en   = edge_ev && (cpha_q ? !lead_ev : lead_ev);

   spi_cmd_shift #(.DW(WORD_W), .LW(LW)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(pop), .load_word(entry_data[WORD_W-1:0]),
      .load_len(new_len), .load_lsb(new_lsb), .shift_en(shift_en), .cap_en(cap_en),
      .miso(miso), .mosi(mosi), .rx_word(rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cs_idx_q  <= 3'd7;
         keep_q    <= 1'b0;
         eoq_q     <= 1'b0;
         cpol_q    <= 1'b0;
         cpha_q    <= 1'b0;
         len_q     <= LW'(WORD_W);
         sck_r     <= 1'b0;
         ecnt      <= '0;
         rx_valid  <= 1'b0;
         rx_data   <= '0;
         xfer_done <= 1'b0;
         tcnt      <= '0;
         eoq_flag  <= 1'b0;
      end else begin
         st_q      <= st_d;
         rx_valid  <= 1'b0;
         xfer_done <= 1'b0;
         if (eoq_clr) eoq_flag <= 1'b0;
         if (pop) begin
            cs_idx_q <= new_idx;
            keep_q   <= entry_data[KEEP_BIT];
            eoq_q    <= entry_data[EOQ_BIT];
            cpol_q   <= new_cpol;
            cpha_q   <= new_cpha;
            len_q    <= new_len;
            if (entry_data[CLR_BIT]) tcnt <= '0;
         end
         if (st_q == ST_LEAD && tmr_zero) begin
            sck_r <= cpol_q;
            ecnt  <= '0;
         end else if (st_q == ST_HOLD && pop) begin
            sck_r <= new_cpol;
            ecnt  <= '0;
         end else if (edge_ev) begin
            sck_r <= ~sck_r;
            ecnt  <= ecnt + ECW'(1);
         end
         if (st_q == ST_TRAIL && tmr_zero) begin
            xfer_done <= 1'b1;
            rx_valid  <= 1'b1;
            rx_data   <= rx_word;
            tcnt      <= tcnt + CNT_W'(1);
            if (eoq_q) eoq_flag <= 1'b1;
         end
      end
   end

   assign sck = (st_q == ST_SHIFT) ? sck_r : cpol_q;

   // chip-select decode with per-output polarity
   logic cs_live;
   logic [NUM_CS-1:0] cs_act;
   assign cs_live = (st_q == ST_LEAD) || (st_q == ST_SHIFT) ||
                    (st_q == ST_TRAIL) || (st_q == ST_HOLD);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign cs_act[g] = cs_live && (cs_idx_q == 3'(g));
      assign cs_out[g] = ~(cs_act[g] ^ cs_active_high[g]);
   end

   assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_act));

   assert_sck_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TRAIL && $past(st_q) == ST_SHIFT) |-> (sck_r == cpol_q));

   assert_no_take_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
      entry_ready |-> !halt);

   assert_eoq_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eoq_flag |-> !entry_ready);

   assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (tcnt == $past(tcnt) + CNT_W'(1)));

   assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_ready && entry_data[CLR_BIT]) |=> (tcnt == '0));

endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;

   localparam int NCS   = 6;
   localparam int NAT   = 2;
   localparam int CW_T  = 4;
   localparam int GAPC  = 3;
   localparam logic [NCS-1:0] CSH = 6'b101010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic entry_valid = 1'b0;
   logic [31:0] entry_data = '0;
   logic entry_ready;
   logic halt = 1'b0;
   logic eoq_clr = 1'b0;
   logic [4*NAT-1:0] attr_len_m1 = '1;
   logic [NAT-1:0] attr_lsb_first = '0;
   logic [NAT-1:0] attr_cpol = '0;
   logic [NAT-1:0] attr_cpha = '0;
   logic miso, sck, mosi, rx_valid, xfer_done, eoq_flag;
   logic [NCS-1:0] cs_out;
   logic [15:0] rx_data;
   logic [CW_T-1:0] tcnt;

   assign miso = ~mosi;

   spi_cmd_engine #(.NUM_CS(NCS), .NUM_ATTR(NAT), .CNT_W(CW_T), .SCK_HALF(1),
                    .LEAD_CYC(2), .TRAIL_CYC(1), .AFTER_XFER(GAPC)) uut (
      .clk(clk), .rst_n(rst_n), .entry_valid(entry_valid), .entry_data(entry_data),
      .entry_ready(entry_ready), .halt(halt), .eoq_clr(eoq_clr),
      .attr_len_m1(attr_len_m1), .attr_lsb_first(attr_lsb_first),
      .attr_cpol(attr_cpol), .attr_cpha(attr_cpha), .cs_active_high(CSH),
      .miso(miso), .sck(sck), .mosi(mosi), .cs_out(cs_out), .rx_valid(rx_valid),
      .rx_data(rx_data), .xfer_done(xfer_done), .tcnt(tcnt), .eoq_flag(eoq_flag)
   );

   always #10 clk = ~clk;

   int checks = 0, failures = 0;
   int exp_cnt = 0;
   int done_pulses = 0, frames = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // serial monitor
   bit mon_cpol = 0, mon_cpha = 0;
   logic prev_sck = 0;
   logic [31:0] mon_seq = 0;
   int mon_cnt = 0;
   int run = 0, last_gap = -1;
   logic [NCS-1:0] act_seen = 0;
   logic [NCS-1:0] act_now;
   assign act_now = ~(cs_out ^ CSH);

   always @(negedge clk) begin
      if (rst_n && sck !== prev_sck) begin
         bit lead;
         lead = (prev_sck == mon_cpol);
         if (mon_cpha ? !lead : lead) begin
            mon_seq = {mon_seq[30:0], mosi};
            mon_cnt++;
         end
      end
      prev_sck = sck;
      act_seen = act_seen | act_now;
      if (act_now == '0) run++;
      else begin
         if (run > 0) last_gap = run;
         run = 0;
      end
      if (xfer_done) done_pulses++;
   end

   function automatic logic [31:0] cmd(input bit keep, input int attr, input bit eoq,
                                       input bit clr, input int idx, input logic [15:0] d);
      return {keep, 3'(attr), eoq, clr, 7'd0, 3'(idx), d};
   endfunction

   task automatic run_frame(input logic [31:0] w, input int len, input bit lsb,
                            input bit cpha, input bit cpol, input string req);
      logic [15:0] d, mask, exp_rx;
      logic [31:0] exp_seq;
      int idx;
      d = w[15:0];
      idx = int'(w[18:16]);
      mask = 16'((32'd1 << len) - 1);
      exp_rx = ~d & mask;
      exp_seq = 0;
      for (int i = 0; i < len; i++)
         exp_seq = {exp_seq[30:0], (lsb ? d[i] : d[len-1-i])};
      entry_data = w;
      entry_valid = 1'b1;
      while (1) begin
         #1;
         if (entry_ready) break;
         @(negedge clk);
      end
      @(posedge clk);
      #1;
      entry_valid = 1'b0;
      mon_cpol = cpol;
      mon_cpha = cpha;
      mon_seq = 0;
      mon_cnt = 0;
      act_seen = 0;
      if (w[26]) exp_cnt = 0;
      do @(negedge clk); while (!rx_valid);
      frames++;
      exp_cnt = (exp_cnt + 1) % (1 << CW_T);
      chk(mon_cnt == len, {req, " R1 edge count"}, mon_cnt, len);
      chk(mon_seq == exp_seq, {req, " R2 R3 serial order"}, mon_seq, exp_seq);
      chk(rx_data == exp_rx, {req, " R12 rx word"}, rx_data, exp_rx);
      chk(sck == cpol, {req, " R3 sck rest"}, sck, cpol);
      chk(act_seen == ((idx < NCS) ? NCS'(1 << idx) : '0), {req, " R4 cs select"},
          act_seen, (idx < NCS) ? (1 << idx) : 0);
      chk(xfer_done == 1'b1, {req, " R9 done pulse"}, xfer_done, 1);
      chk(int'(tcnt) == exp_cnt, {req, " R8 count"}, tcnt, exp_cnt);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_out == ~CSH, "R4 reset cs idle", cs_out, ~CSH);
      chk(sck == 1'b0 && entry_ready == 1'b0, "R3 reset sck", sck, 0);
      chk(tcnt == '0 && eoq_flag == 1'b0 && rx_valid == 1'b0, "R8 reset state", tcnt, 0);

      // main sweep on attribute set 1
      for (int mode = 0; mode < 4; mode++)
         for (int lsb = 0; lsb < 2; lsb++)
            for (int len = 4; len <= 16; len++)
               for (int pat = 0; pat < 2; pat++) begin
                  logic [15:0] d;
                  d = pat ? 16'(16'h5A3C ^ (len * 16'h0911)) : 16'(16'hC3A5 + len * 16'h1357);
                  attr_len_m1[7:4] = 4'(len - 1);
                  attr_lsb_first[1] = lsb[0];
                  attr_cpha[1] = mode[0];
                  attr_cpol[1] = mode[1];
                  run_frame(cmd(0, 1, 0, 0, (len + pat) % 6, d), len, lsb[0], mode[0], mode[1], "sweep");
                  chk(last_gap == GAPC + 1, "R6 gap after frame", last_gap, GAPC + 1);
               end

      // short length fields clamp to 4 bits
      for (int v = 0; v < 3; v++) begin
         attr_len_m1[3:0] = 4'(v);
         run_frame(cmd(0, 0, 0, 0, 2, 16'hFFF6), 4, 0, 0, 0, "R1 clamp");
      end
      attr_len_m1[3:0] = 4'd15;

      // continuous chip select to the same target
      run_frame(cmd(1, 0, 0, 0, 3, 16'h1234), 16, 0, 0, 0, "R5 first");
      last_gap = -1;
      run_frame(cmd(0, 0, 0, 0, 3, 16'hBEEF), 16, 0, 0, 0, "R5 second");
      chk(last_gap == -1, "R5 no inactive cycle", last_gap, -1);
      // keep set but new target forces a gap
      run_frame(cmd(1, 0, 0, 0, 1, 16'h0F0F), 16, 0, 0, 0, "R6 keep");
      last_gap = -1;
      run_frame(cmd(0, 0, 0, 0, 4, 16'hF00D), 16, 0, 0, 0, "R6 switch");
      chk(last_gap == GAPC + 1, "R6 gap on new target", last_gap, GAPC + 1);
      // index outside the output range selects nothing
      run_frame(cmd(0, 0, 0, 0, 7, 16'h4321), 16, 0, 0, 0, "R4 none");

      // counter clear and wrap
      run_frame(cmd(0, 0, 0, 1, 0, 16'h0001), 16, 0, 0, 0, "R7 clear");
      chk(tcnt == CW_T'(1), "R7 count after clear", tcnt, 1);
      for (int k = 0; k < 15; k++)
         run_frame(cmd(0, 0, 0, 0, 5, 16'(k * 16'h0777)), 16, 0, 0, 0, "R8 wrap run");
      chk(tcnt == '0, "R8 wrapped to zero", tcnt, 0);

      // end of queue
      run_frame(cmd(0, 0, 1, 0, 2, 16'hA0A0), 16, 0, 0, 0, "R10 last");
      chk(eoq_flag == 1'b1, "R10 flag set", eoq_flag, 1);
      @(negedge clk);
      chk(xfer_done == 1'b0, "R9 done one cycle", xfer_done, 0);
      entry_data = cmd(0, 0, 0, 0, 2, 16'h5555);
      entry_valid = 1'b1;
      begin
         int seen = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (entry_ready || act_now != '0) seen++;
         end
         chk(seen == 0, "R10 blocked while flag set", seen, 0);
      end
      eoq_clr = 1'b1;
      @(negedge clk);
      eoq_clr = 1'b0;
      chk(eoq_flag == 1'b0, "R10 flag cleared", eoq_flag, 1'b0);
      run_frame(cmd(0, 0, 0, 0, 2, 16'h5555), 16, 0, 0, 0, "R10 resumed");

      // halt before a frame
      halt = 1'b1;
      entry_data = cmd(0, 0, 0, 0, 0, 16'h3C3C);
      entry_valid = 1'b1;
      begin
         int seen = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (entry_ready || act_now != '0) seen++;
         end
         chk(seen == 0, "R11 no start while halted", seen, 0);
      end
      halt = 1'b0;
      run_frame(cmd(0, 0, 0, 0, 0, 16'h3C3C), 16, 0, 0, 0, "R11 released");

      // halt raised during a frame
      fork
         begin
            repeat (6) @(negedge clk);
            halt = 1'b1;
         end
      join_none
      run_frame(cmd(0, 0, 0, 0, 1, 16'h9876), 16, 0, 0, 0, "R11 frame completes");
      entry_data = cmd(0, 0, 0, 0, 1, 16'h1111);
      entry_valid = 1'b1;
      begin
         int seen = 0;
         for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (entry_ready) seen++;
         end
         chk(seen == 0, "R11 next blocked", seen, 0);
      end
      halt = 1'b0;
      run_frame(cmd(0, 0, 0, 0, 1, 16'h1111), 16, 0, 0, 0, "R11 after halt");

      repeat (2) @(negedge clk);
      chk(done_pulses == frames, "R9 one pulse per frame", done_pulses, frames);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule